// File: doc/BRIEF.md
# TLB Maintenance Register Interface

This block is the software-facing side of a translation buffer. A small set of numbered registers gives software indirect access to a table of translation entries. An index register chooses an entry. A tag port and a data port then move that entry's words in or out. Two further registers hold the current process identifier and a zone protection word. A write-only search register runs an associative lookup over the whole table and leaves the result in the index register. The block owns the entry storage, including a per-entry owner identifier, and the lookup logic that a search uses. Address translation for ordinary loads and stores is outside this block.

Each access presents a register number, a read or write strobe, 32 bits of write data and an upper-half flag. Read data is combinational in the strobe cycle. Writes and read side effects take place at the next rising clock edge. Two configuration inputs gate everything: a mode setting and a two-bit access level. A search takes one extra cycle, and a busy output covers that cycle.

Top module: `tlb_maint_if`

## Requirements
- R1: A synchronous active-high reset clears the index, PID and zone registers and every entry word and owner field to zero, and drops busy and reg_err.
- R2: A write to the index register (number 0) changes only bits 30:0, and bit 31 keeps its value. The low log2(ENTRIES) bits select the entry, and any higher bits do not affect the selection.
- R3: A tag port write (number 1) stores the word at the selected entry and records the PID register's bits 7:0 as that entry's owner. A data port write (number 2) stores the lower data word when ext=0 and the upper data word when ext=1. Reads return the same words.
- R4: A tag port read returns the selected tag word and loads the PID register with that entry's owner, zero-extended.
- R5: The search register (number 5) always reads as zero. A write to it looks up `wdata & 0xFFFFFC00`. On a hit, the whole index register becomes the matching entry number, which clears bit 31. If several entries match, the lowest-numbered one wins.
- R6: When a search misses, bit 31 of the index register is set and bits 30:0 keep their values.
- R7: An entry matches when tag bit 0 (valid) is set and the address agrees with tag bits 31:10 above the page span. The page span is 1 KiB × 4^code, where the code is tag bits 3:1. The owner must also match: an owner of 0 matches any PID, and any other owner must equal PID bits 7:0.
- R8: The zone of an entry is its lower data word bits 3:0. Zone z reads the field at zone register bits [31-2z:30-2z]. When that field is 00, a search made with user_mode=1 skips the entry. Other field values do not affect a search. A zone number at or above ZONES counts as field 01.
- R9: An access with ext=1 is legal only on the data port. Any other register accessed with ext=1 reads as zero, and the write has no effect.
- R10: Reads of the tag port, the data port, the PID register and the zone register (number 4) return zero unless cfg_access bit 0 is 1. Writes to the PID, zone and search registers take effect only when cfg_access is 2 or 3.
- R11: When cfg_mode is below 2, or cfg_access is 0, every register reads as zero and writes have no effect.
- R12: Register numbers 6 and 7 are undefined. They read as zero, and writes to them have no effect. Any strobe to one of them raises reg_err for exactly the following cycle.
- R13: busy is high for exactly the one cycle after an accepted search write. The index is updated at the end of that cycle. Writes, and the PID load of a tag read, are dropped while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Translation mode; 2 or 3 enables the register interface |
| cfg_access | input | 2 | Access level; bit 0 enables reads, a value of 2 or more enables protected writes |
| user_mode | input | 1 | Privilege of a search: 1 is user level |
| reg_sel | input | 3 | Register number |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| ext | input | 1 | Selects the upper 32-bit word of the data port |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the strobe cycle |
| busy | output | 1 | A search result is pending |
| reg_err | output | 1 | One-cycle pulse after a strobe to an undefined register |

## Verification
The bench checks that bit 31 of the index register survives direct writes. A design that stored the full word would let software forge or clear a miss. Searches cover a page span larger than 1 KiB, an owner of zero against a non-zero PID, a zone field that hides an entry only from user level, and two overlapping entries. These cases catch a mask computed from the wrong code bits, a too-strict owner compare, a privilege test that also blocks supervisor searches, and a priority encoder that picks the highest match. A write issued in the busy cycle must not reach the PID register. A tag read must overwrite the PID, and the bench confirms this through a later PID read. The gating by mode, access level and the upper-half flag is tested on both reads and writes, so an ungated write path shows up as a changed register.

// File: rtl/tlb_maint_pkg.sv
package tlb_maint_pkg;

    typedef enum logic [2:0] {
        RS_INDEX  = 3'd0,
        RS_TAG    = 3'd1,
        RS_DATA   = 3'd2,
        RS_PID    = 3'd3,
        RS_ZONE   = 3'd4,
        RS_SEARCH = 3'd5
    } reg_sel_e;

    localparam logic [31:0] PAGE_NUM_MASK = 32'hFFFF_FC00;
    localparam logic [31:0] MISS_FLAG     = 32'h8000_0000;

    typedef struct packed {
        logic       hit;
        logic [7:0] idx;
    } search_res_t;

    // Address bits covered by a page of the given size code: 1 KiB * 4^code.
    function automatic logic [31:0] span_keep_mask(input logic [2:0] code);
        return ~((32'd1024 << {code, 1'b0}) - 32'd1);
    endfunction

    // Two-bit zone field for a zone number; out-of-range zones act as 01.
    function automatic logic [1:0] zone_field(input logic [31:0] zone_word,
                                              input logic [3:0]  zsel,
                                              input int          nzones);
        int sh;
        if (int'(zsel) >= nzones) return 2'b01;
        sh = 30 - 2 * int'(zsel);
        return zone_word[sh +: 2];
    endfunction

endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store #(
    parameter  int ENTRIES = 16,
    localparam int IW      = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we_tag,
    input  logic          we_lo,
    input  logic          we_hi,
    input  logic [IW-1:0] widx,
    input  logic [31:0]   wdata,
    input  logic [7:0]    tid_in,
    output logic [31:0]   tag_q [ENTRIES],
    output logic [31:0]   lo_q  [ENTRIES],
    output logic [31:0]   hi_q  [ENTRIES],
    output logic [7:0]    tid_q [ENTRIES]
);

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        logic sel;
        assign sel = (widx == IW'(e));

        always_ff @(posedge clk) begin
            if (rst) begin
                tag_q[e] <= '0;
                lo_q[e]  <= '0;
                hi_q[e]  <= '0;
                tid_q[e] <= '0;
            end else if (sel) begin
                if (we_tag) begin
                    tag_q[e] <= wdata;
                    tid_q[e] <= tid_in;
                end
                if (we_lo) lo_q[e] <= wdata;
                if (we_hi) hi_q[e] <= wdata;
            end
        end
    end

endmodule

// File: rtl/tlb_assoc_search.sv
module tlb_assoc_search
    import tlb_maint_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int ZONES   = 16
) (
    input  logic [31:0]  tag_q [ENTRIES],
    input  logic [3:0]   zsel  [ENTRIES],
    input  logic [7:0]   tid_q [ENTRIES],
    input  logic [7:0]   pid8,
    input  logic [31:0]  zone_word,
    input  logic         user,
    input  logic [31:0]  addr,
    output search_res_t  res
);

    logic [ENTRIES-1:0] hit_vec;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        logic [31:0] keep;
        logic        addr_ok, tid_ok, zone_ok;
        assign keep    = span_keep_mask(tag_q[e][3:1]) & PAGE_NUM_MASK;
        assign addr_ok = (((addr ^ tag_q[e]) & keep) == '0);
        assign tid_ok  = (tid_q[e] == 8'd0) || (tid_q[e] == pid8);
        assign zone_ok = !(user && (zone_field(zone_word, zsel[e], ZONES) == 2'b00));
        assign hit_vec[e] = tag_q[e][0] && addr_ok && tid_ok && zone_ok;
    end

    // Lowest-numbered matching entry wins.
    always_comb begin
        res = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (hit_vec[e]) begin
                res.hit = 1'b1;
                res.idx = 8'(e);
            end
        end
    end

endmodule

// File: rtl/tlb_maint_if.sv
module tlb_maint_if
    import tlb_maint_pkg::*;
#(
    parameter  int ENTRIES = 16,
    parameter  int ZONES   = 16,
    localparam int IW      = $clog2(ENTRIES)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  cfg_mode,
    input  logic [1:0]  cfg_access,
    input  logic        user_mode,
    input  logic [2:0]  reg_sel,
    input  logic        rd_en,
    input  logic        wr_en,
    input  logic        ext,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        busy,
    output logic        reg_err
);

    logic [31:0] idx_q, pid_q, zone_q, srch_addr_q;
    logic        busy_q, err_q, srch_user_q;

    logic [31:0] tag_q [ENTRIES];
    logic [31:0] lo_q  [ENTRIES];
    logic [31:0] hi_q  [ENTRIES];
    logic [7:0]  tid_q [ENTRIES];
    logic [3:0]  zsel  [ENTRIES];

    reg_sel_e    rsel;
    logic        active, ext_ok, rd_perm, wr_priv, undefined_sel;
    logic        wr_go, rd_go;
    logic [IW-1:0] cur;
    search_res_t sres;

    assign rsel          = reg_sel_e'(reg_sel);
    assign active        = (cfg_mode >= 2'd2) && (cfg_access != 2'd0);
    assign ext_ok        = !ext || (rsel == RS_DATA);
    assign rd_perm       = cfg_access[0];
    assign wr_priv       = (cfg_access >= 2'd2);
    assign undefined_sel = (reg_sel >= 3'd6);
    assign wr_go         = wr_en && active && ext_ok && !busy_q;
    assign rd_go         = rd_en && active && ext_ok;
    assign cur           = idx_q[IW-1:0];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_zsel
        assign zsel[e] = lo_q[e][3:0];
    end

    tlb_entry_store #(.ENTRIES(ENTRIES)) u_store (
        .clk    (clk),
        .rst    (rst),
        .we_tag (wr_go && rsel == RS_TAG),
        .we_lo  (wr_go && rsel == RS_DATA && !ext),
        .we_hi  (wr_go && rsel == RS_DATA && ext),
        .widx   (cur),
        .wdata  (wdata),
        .tid_in (pid_q[7:0]),
        .tag_q  (tag_q),
        .lo_q   (lo_q),
        .hi_q   (hi_q),
        .tid_q  (tid_q)
    );

    tlb_assoc_search #(.ENTRIES(ENTRIES), .ZONES(ZONES)) u_search (
        .tag_q     (tag_q),
        .zsel      (zsel),
        .tid_q     (tid_q),
        .pid8      (pid_q[7:0]),
        .zone_word (zone_q),
        .user      (srch_user_q),
        .addr      (srch_addr_q),
        .res       (sres)
    );

    always_comb begin
        rdata = '0;
        if (rd_go) begin
            unique case (rsel)
                RS_INDEX: rdata = idx_q;
                RS_TAG:   rdata = rd_perm ? tag_q[cur] : '0;
                RS_DATA:  rdata = rd_perm ? (ext ? hi_q[cur] : lo_q[cur]) : '0;
                RS_PID:   rdata = rd_perm ? pid_q : '0;
                RS_ZONE:  rdata = rd_perm ? zone_q : '0;
                default:  rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q       <= '0;
            pid_q       <= '0;
            zone_q      <= '0;
            srch_addr_q <= '0;
            srch_user_q <= 1'b0;
            busy_q      <= 1'b0;
            err_q       <= 1'b0;
        end else begin
            err_q <= (rd_en || wr_en) && undefined_sel;
            if (busy_q) begin
                busy_q <= 1'b0;
                idx_q  <= sres.hit ? 32'(sres.idx) : (idx_q | MISS_FLAG);
            end else begin
                if (rd_go && rd_perm && rsel == RS_TAG)
                    pid_q <= 32'(tid_q[cur]);
                if (wr_go) begin
                    unique case (rsel)
                        RS_INDEX: idx_q[30:0] <= wdata[30:0];
                        RS_PID:    if (wr_priv) pid_q  <= wdata;
                        RS_ZONE:   if (wr_priv) zone_q <= wdata;
                        RS_SEARCH: if (wr_priv) begin
                            busy_q      <= 1'b1;
                            srch_addr_q <= wdata & PAGE_NUM_MASK;
                            srch_user_q <= user_mode;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    assign busy    = busy_q;
    assign reg_err = err_q;

endmodule

// File: rtl/tlb_maint_chk.sv
module tlb_maint_chk (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  cfg_mode,
    input logic [1:0]  cfg_access,
    input logic [2:0]  reg_sel,
    input logic        rd_en,
    input logic        wr_en,
    input logic        ext,
    input logic [31:0] wdata,
    input logic [31:0] rdata,
    input logic        busy,
    input logic        reg_err,
    input logic [31:0] idx_q,
    input logic [31:0] pid_q
);

    logic live;
    assign live = (cfg_mode >= 2'd2) && (cfg_access != 2'd0);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (idx_q == '0 && pid_q == '0 && !busy && !reg_err));

    // R2
    index_msb_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !busy && live && !ext && reg_sel == 3'd0)
        |=> (idx_q[30:0] == $past(wdata[30:0]) && idx_q[31] == $past(idx_q[31])));

    // R9
    ext_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && ext && reg_sel != 3'd2) |-> rdata == '0);

    // R11
    idle_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !live) |-> rdata == '0);

    // R12
    bad_reg_chk: assert property (@(posedge clk) disable iff (rst)
        ((rd_en || wr_en) && reg_sel >= 3'd6) |=> reg_err);

    // R12
    err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !((rd_en || wr_en) && reg_sel >= 3'd6) |=> !reg_err);

    // R13
    search_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !busy && live && !ext && cfg_access >= 2'd2 && reg_sel == 3'd5) |=> busy);

    // R13
    busy_single_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy);

    // R13
    busy_pid_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(pid_q));

endmodule

bind tlb_maint_if tlb_maint_chk u_chk (.*);

// File: tb/tlb_maint_if_bench.sv
module tlb_maint_if_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_mode = 2'd2;
    logic [1:0]  cfg_access = 2'd3;
    logic        user_mode = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        ext = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        busy, reg_err;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    tlb_maint_if u_tlb_maint_if (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_access(cfg_access),
        .user_mode(user_mode), .reg_sel(reg_sel), .rd_en(rd_en), .wr_en(wr_en),
        .ext(ext), .wdata(wdata), .rdata(rdata), .busy(busy), .reg_err(reg_err)
    );

    // {is_read, reg, ext, data, expected, requirement}
    localparam int NV = 15;
    localparam logic [72:0] VECS [NV] = '{
        {1'b0, 3'd3, 1'b0, 32'h0000_0005, 32'h0,           4'd3},  // R3 PID source
        {1'b0, 3'd0, 1'b0, 32'h8000_0003, 32'h0,           4'd2},  // R2
        {1'b1, 3'd0, 1'b0, 32'h0,         32'h0000_0003,   4'd2},  // R2 bit31 kept
        {1'b0, 3'd1, 1'b0, 32'h1234_5C01, 32'h0,           4'd3},  // R3
        {1'b0, 3'd2, 1'b0, 32'h0000_00A2, 32'h0,           4'd3},  // R3
        {1'b0, 3'd2, 1'b1, 32'hDEAD_BEEF, 32'h0,           4'd3},  // R3
        {1'b1, 3'd2, 1'b0, 32'h0,         32'h0000_00A2,   4'd3},  // R3
        {1'b1, 3'd2, 1'b1, 32'h0,         32'hDEAD_BEEF,   4'd3},  // R3
        {1'b0, 3'd3, 1'b0, 32'h0000_0077, 32'h0,           4'd4},  // R4
        {1'b1, 3'd1, 1'b0, 32'h0,         32'h1234_5C01,   4'd4},  // R4
        {1'b1, 3'd3, 1'b0, 32'h0,         32'h0000_0005,   4'd4},  // R4 PID loaded
        {1'b1, 3'd1, 1'b1, 32'h0,         32'h0,           4'd9},  // R9
        {1'b0, 3'd4, 1'b0, 32'hC000_0000, 32'h0,           4'd10}, // R10
        {1'b1, 3'd4, 1'b0, 32'h0,         32'hC000_0000,   4'd10}, // R10
        {1'b1, 3'd5, 1'b0, 32'h0,         32'h0,           4'd5}   // R5
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_wr(input logic [2:0] s, input logic e, input logic [31:0] d);
        @(negedge clk);
        reg_sel = s; ext = e; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; ext = 1'b0;
    endtask

    task automatic do_rd(input logic [2:0] s, input logic e, output logic [31:0] q);
        @(negedge clk);
        reg_sel = s; ext = e; rd_en = 1'b1;
        #1 q = rdata;
        @(negedge clk);
        rd_en = 1'b0; ext = 1'b0;
    endtask

    task automatic search(input logic [31:0] a, input logic u);
        user_mode = u;
        do_wr(3'd5, 1'b0, a);
        check("R13", "busy after search write", 32'(busy), 32'd1);
    endtask

    task automatic expect_rd(input string req, input string what, input logic [2:0] s,
                             input logic e, input logic [31:0] exp);
        logic [31:0] q;
        do_rd(s, e, q);
        check(req, what, q, exp);
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(4 * 20000);
        n_bad++;
        $display("FAIL watchdog: got running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1", "busy", 32'(busy), 32'd0);
        check("R1", "reg_err", 32'(reg_err), 32'd0);
        expect_rd("R1", "index", 3'd0, 1'b0, 32'h0);
        expect_rd("R1", "pid", 3'd3, 1'b0, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [72:0] v;
            logic [31:0] q;
            v = VECS[i];
            if (v[72]) begin
                do_rd(v[71:69], v[68], q);
                check($sformatf("R%0d", v[3:0]), $sformatf("vector %0d", i), q, v[35:4]);
            end else begin
                do_wr(v[71:69], v[68], v[67:36]);
            end
        end

        // R5 hit at supervisor level
        do_wr(3'd0, 1'b0, 32'h0);
        search(32'h1234_5DFF, 1'b0);
        expect_rd("R5", "search hit index", 3'd0, 1'b0, 32'h0000_0003);
        // R8 zone field 00 hides from user level, R6 miss sets bit31
        search(32'h1234_5DFF, 1'b1);
        expect_rd("R8", "user search zone 00", 3'd0, 1'b0, 32'h8000_0003);
        do_wr(3'd4, 1'b0, 32'h0400_0000);
        search(32'h1234_5DFF, 1'b1);
        expect_rd("R8", "user search zone 01", 3'd0, 1'b0, 32'h0000_0003);
        // R7 owner mismatch, R13 write during busy dropped
        do_wr(3'd3, 1'b0, 32'h0000_0009);
        search(32'h1234_5DFF, 1'b0);
        reg_sel = 3'd3; wdata = 32'h55; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        check("R13", "busy dropped", 32'(busy), 32'd0);
        expect_rd("R13", "pid after busy write", 3'd3, 1'b0, 32'h0000_0009);
        expect_rd("R7", "owner mismatch miss", 3'd0, 1'b0, 32'h8000_0003);
        // R7 64 KiB entry with owner 0
        do_wr(3'd3, 1'b0, 32'h0);
        do_wr(3'd0, 1'b0, 32'h1);
        do_wr(3'd1, 1'b0, 32'h4000_0007);
        do_wr(3'd3, 1'b0, 32'h9);
        search(32'h4000_FC00, 1'b0);
        expect_rd("R7", "64K page hit", 3'd0, 1'b0, 32'h0000_0001);
        search(32'h4001_0000, 1'b0);
        expect_rd("R6", "past span miss", 3'd0, 1'b0, 32'h8000_0001);
        // R5 priority: 256 KiB entry 0 overlaps entry 1
        do_wr(3'd3, 1'b0, 32'h0);
        do_wr(3'd0, 1'b0, 32'h0);
        do_wr(3'd1, 1'b0, 32'h4000_0009);
        do_wr(3'd3, 1'b0, 32'h9);
        do_wr(3'd0, 1'b0, 32'h5);
        search(32'h4000_FC00, 1'b0);
        expect_rd("R5", "lowest entry wins", 3'd0, 1'b0, 32'h0000_0000);

        // R10 access levels
        cfg_access = 2'd2;
        expect_rd("R10", "pid read without bit0", 3'd3, 1'b0, 32'h0);
        cfg_access = 2'd1;
        expect_rd("R10", "pid read level 1", 3'd3, 1'b0, 32'h9);
        do_wr(3'd3, 1'b0, 32'h33);
        do_wr(3'd4, 1'b0, 32'h0);
        do_wr(3'd0, 1'b0, 32'h2);
        cfg_access = 2'd3;
        expect_rd("R10", "pid write blocked", 3'd3, 1'b0, 32'h9);
        expect_rd("R10", "zone write blocked", 3'd4, 1'b0, 32'h0400_0000);
        expect_rd("R10", "index write at level 1", 3'd0, 1'b0, 32'h2);

        // R11 disabled configurations
        cfg_mode = 2'd1;
        expect_rd("R11", "index read mode 1", 3'd0, 1'b0, 32'h0);
        do_wr(3'd0, 1'b0, 32'h7);
        cfg_mode = 2'd2;
        expect_rd("R11", "index write ignored", 3'd0, 1'b0, 32'h2);
        cfg_access = 2'd0;
        expect_rd("R11", "pid read access 0", 3'd3, 1'b0, 32'h0);
        do_wr(3'd3, 1'b0, 32'h44);
        cfg_access = 2'd3;
        expect_rd("R11", "pid write ignored", 3'd3, 1'b0, 32'h9);

        // R9 illegal upper-half writes
        do_wr(3'd1, 1'b1, 32'hFFFF_FFFF);
        do_wr(3'd3, 1'b1, 32'h66);
        expect_rd("R9", "pid after ext write", 3'd3, 1'b0, 32'h9);
        expect_rd("R9", "tag after ext write", 3'd1, 1'b0, 32'h0);
        expect_rd("R4", "pid loaded with owner 0", 3'd3, 1'b0, 32'h0);

        // R2 index bits above the entry field do not select
        do_wr(3'd0, 1'b0, 32'h13);
        expect_rd("R2", "high index bits ignored", 3'd1, 1'b0, 32'h1234_5C01);

        // R12 undefined registers
        do_wr(3'd6, 1'b0, 32'h1);
        check("R12", "reg_err pulse", 32'(reg_err), 32'd1);
        @(negedge clk);
        check("R12", "reg_err cleared", 32'(reg_err), 32'd0);
        expect_rd("R12", "undefined read", 3'd7, 1'b0, 32'h0);
        expect_rd("R12", "index after undefined write", 3'd0, 1'b0, 32'h13);

        // R1 reset again
        do_reset();
        expect_rd("R1", "index after reset", 3'd0, 1'b0, 32'h0);
        expect_rd("R1", "zone after reset", 3'd4, 1'b0, 32'h0);
        expect_rd("R1", "entry 0 tag after reset", 3'd1, 1'b0, 32'h0);
        check("R1", "busy after reset", 32'(busy), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule